// File: doc/BRIEF.md
# Sixteen-Lag Complex Spreading-Code Correlator

This block correlates a stream of complex baseband samples against a short window of a binary spreading code at sixteen neighbouring delays at once. Every accepted operation brings one beat of eight complex samples and a window of twenty-three code chips. Each chip is a two-bit value whose real and imaginary parts are each +1 or -1. For every lag the block forms the eight complex products of samples and chips and adds their sum into that lag's accumulator. Software that walks a long code through the correlator steps the window by one beat per operation and reads the sixteen accumulators when it wants them.

A signed trim value on each operation can switch off chips at the low end or the high end of the window. Lags whose taps run past that edge then collect only part of their sum. This is how a caller handles the seam where one code period ends and the next one begins. A clear flag makes an operation overwrite the accumulators with its own sums instead of adding to them. The products need no multiplier, because each one comes from negating or swapping the sample components.

Top module: `pn_lag_correlator`

## Requirements
- R1: With no trim, accumulator k (0..15) adds sum over i = 0..7 of S_i * C_(15-k+i). S_i is sample i of the beat and C_m is chip m of the window. Lag 0 therefore pairs S7 with C22, and lag 15 pairs S0 with C0.
- R2: Chip m sits at code bits [2m+1:2m]. Bit 2m gives the sign of the real part and bit 2m+1 the sign of the imaginary part. A set bit means -1 and a clear bit means +1, so 2'b11 is -1-j and 2'b00 is +1+j.
- R3: Sample i sits at data bits [16i+15:16i]. The low byte is the signed real part a and the high byte is the signed imaginary part b. With a chip c+jd, the product adds c*a - d*b to the real sum and d*a + c*b to the imaginary sum.
- R4: A negative trim -n (two's complement, 6 bits) keeps only chips with index m >= n. With -7, lag 15 gets one tap, lag 14 two and lag 13 three. With -15, lag 1 gets seven taps, lag 7 one, and lags 8..15 get nothing. A trim of -23 or below zeroes every contribution.
- R5: A positive trim +n keeps only chips with index m < n. With +15, lag 0 gets nothing, lag 1 one tap (S0*C14), lag 7 seven, and lags 8..15 all eight. A trim of zero keeps every chip.
- R6: An operation with the clear flag set loads each accumulator with that operation's own sum and discards the earlier total.
- R7: While no operation is accepted, the accumulators keep their values, whatever the data, code, trim and clear inputs carry.
- R8: Each accumulator keeps separate 16-bit two's-complement real and imaginary totals that wrap on overflow.
- R9: During reset in_ready is low and every accumulator is cleared to zero. Out of reset in_ready is high.
- R10: The read port returns the real and imaginary totals of the lag chosen by rd_idx, combinationally. The effect of an operation is visible there from the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | Operations are accepted |
| in_data | input | 128 | Eight complex samples, 16 bits each |
| in_code | input | 46 | Twenty-three 2-bit chips |
| in_cut | input | 6 | Signed window trim |
| in_clr | input | 1 | Overwrite instead of accumulate |
| rd_idx | input | 4 | Lag selected for reading |
| rd_re | output | 16 | Real total of the selected lag |
| rd_im | output | 16 | Imaginary total of the selected lag |

## Verification
All state lives in the accumulator bank. A wrong internal value therefore shows on rd_re or rd_im as soon as the bench selects that lag, which is the cycle after the operation that caused it. A misrouted chip or a wrong trim bound changes only some lags and only some tap counts. The stimulus therefore uses constant samples and chips, so that each total equals its tap count, and reads all sixteen lags after every trim pattern. Faults that build up over several operations, such as a missed wrap or a lost clear, show once the next multi-operation sequence is read back.

// File: rtl/cor_pkg.sv
package cor_pkg;

    localparam int DEF_LAGS = 16;
    localparam int DEF_TAPS = 8;
    localparam int DEF_SW   = 8;
    localparam int DEF_AW   = 16;
    localparam int DEF_CW   = 6;

    // one code chip: upper bit flips the imaginary unit, lower bit the real unit
    typedef struct packed {
        logic im_neg;
        logic re_neg;
    } chip_t;

    // window trim rule: below zero removes low chips, above zero removes high chips
    function automatic logic chip_live(int m, int trim);
        if (trim < 0)
            return (m >= -trim);
        else if (trim > 0)
            return (m < trim);
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/cor_tap_mask.sv
module cor_tap_mask #(
    parameter int LAGS = cor_pkg::DEF_LAGS,
    parameter int TAPS = cor_pkg::DEF_TAPS,
    parameter int CW   = cor_pkg::DEF_CW
) (
    input  logic signed [CW-1:0]         trim,
    output logic [LAGS-1:0][TAPS-1:0]    live
);
    logic signed [31:0] trim_i;
    assign trim_i = 32'(trim);

    for (genvar k = 0; k < LAGS; k++) begin : g_lag
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign live[k][i] = cor_pkg::chip_live((LAGS - 1 - k) + i, trim_i);
        end
    end
endmodule

// File: rtl/cor_lag_sum.sv
module cor_lag_sum #(
    parameter int TAPS = cor_pkg::DEF_TAPS,
    parameter int SW   = cor_pkg::DEF_SW,
    parameter int SUMW = SW + 2 + $clog2(TAPS)
) (
    input  logic [TAPS-1:0][2*SW-1:0] samples,
    input  logic [TAPS-1:0][1:0]      chips,
    input  logic [TAPS-1:0]           live,
    output logic [SUMW-1:0]           sum_re,
    output logic [SUMW-1:0]           sum_im
);
    always_comb begin
        logic [SUMW-1:0] a, b, t_re, t_im;
        cor_pkg::chip_t ch;
        sum_re = '0;
        sum_im = '0;
        for (int i = 0; i < TAPS; i++) begin
            a  = {{(SUMW-SW){samples[i][SW-1]}},   samples[i][SW-1:0]};
            b  = {{(SUMW-SW){samples[i][2*SW-1]}}, samples[i][2*SW-1:SW]};
            ch = chips[i];
            // real: c*a - d*b ; imaginary: d*a + c*b
            t_re = (ch.re_neg ? -a : a) + (ch.im_neg ? b : -b);
            t_im = (ch.im_neg ? -a : a) + (ch.re_neg ? -b : b);
            if (live[i]) begin
                sum_re = sum_re + t_re;
                sum_im = sum_im + t_im;
            end
        end
    end
endmodule

// File: rtl/cor_acc_bank.sv
module cor_acc_bank #(
    parameter int LAGS = cor_pkg::DEF_LAGS,
    parameter int AW   = cor_pkg::DEF_AW,
    parameter int SUMW = 13,
    localparam int IW  = $clog2(LAGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       fresh,
    input  logic [LAGS-1:0][SUMW-1:0]  sum_re,
    input  logic [LAGS-1:0][SUMW-1:0]  sum_im,
    input  logic [IW-1:0]              rd_idx,
    output logic [LAGS-1:0][AW-1:0]    acc_re,
    output logic [LAGS-1:0][AW-1:0]    acc_im,
    output logic [AW-1:0]              rd_re,
    output logic [AW-1:0]              rd_im
);
    for (genvar k = 0; k < LAGS; k++) begin : g_acc
        logic [AW-1:0] ext_re, ext_im, base_re, base_im;
        assign ext_re  = {{(AW-SUMW){sum_re[k][SUMW-1]}}, sum_re[k]};
        assign ext_im  = {{(AW-SUMW){sum_im[k][SUMW-1]}}, sum_im[k]};
        assign base_re = fresh ? '0 : acc_re[k];
        assign base_im = fresh ? '0 : acc_im[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_re[k] <= '0;
                acc_im[k] <= '0;
            end else if (load) begin
                acc_re[k] <= base_re + ext_re;
                acc_im[k] <= base_im + ext_im;
            end
        end
    end

    assign rd_re = acc_re[rd_idx];
    assign rd_im = acc_im[rd_idx];
endmodule

// File: rtl/pn_lag_correlator.sv
module pn_lag_correlator #(
    parameter int LAGS = cor_pkg::DEF_LAGS,
    parameter int TAPS = cor_pkg::DEF_TAPS,
    parameter int SW   = cor_pkg::DEF_SW,
    parameter int AW   = cor_pkg::DEF_AW,
    parameter int CW   = cor_pkg::DEF_CW,
    localparam int CHIPS = LAGS + TAPS - 1,
    localparam int IW    = $clog2(LAGS),
    localparam int SUMW  = SW + 2 + $clog2(TAPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [TAPS*2*SW-1:0]   in_data,
    input  logic [2*CHIPS-1:0]     in_code,
    input  logic signed [CW-1:0]   in_cut,
    input  logic                   in_clr,
    input  logic [IW-1:0]          rd_idx,
    output logic [AW-1:0]          rd_re,
    output logic [AW-1:0]          rd_im
);
    logic                          fire;
    logic [LAGS-1:0][TAPS-1:0]     live_w;
    logic [LAGS-1:0][SUMW-1:0]     sum_re_w, sum_im_w;
    logic [LAGS-1:0][AW-1:0]       acc_re_w, acc_im_w;
    logic [TAPS-1:0][2*SW-1:0]     samples_w;

    assign in_ready  = ~rst;
    assign fire      = in_valid & in_ready;
    assign samples_w = in_data;

    cor_tap_mask #(.LAGS(LAGS), .TAPS(TAPS), .CW(CW)) u_mask (
        .trim (in_cut),
        .live (live_w)
    );

    for (genvar k = 0; k < LAGS; k++) begin : g_lag
        logic [TAPS-1:0][1:0] chips_k;
        for (genvar i = 0; i < TAPS; i++) begin : g_chip
            assign chips_k[i] = in_code[2*((LAGS-1-k)+i) +: 2];
        end
        cor_lag_sum #(.TAPS(TAPS), .SW(SW), .SUMW(SUMW)) u_sum (
            .samples (samples_w),
            .chips   (chips_k),
            .live    (live_w[k]),
            .sum_re  (sum_re_w[k]),
            .sum_im  (sum_im_w[k])
        );
    end

    cor_acc_bank #(.LAGS(LAGS), .AW(AW), .SUMW(SUMW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (fire),
        .fresh  (in_clr),
        .sum_re (sum_re_w),
        .sum_im (sum_im_w),
        .rd_idx (rd_idx),
        .acc_re (acc_re_w),
        .acc_im (acc_im_w),
        .rd_re  (rd_re),
        .rd_im  (rd_im)
    );
endmodule

// File: rtl/cor_lag_checker.sv
module cor_lag_checker #(
    parameter int LAGS = 16,
    parameter int TAPS = 8,
    parameter int AW   = 16,
    parameter int SUMW = 13,
    parameter int CW   = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      fire,
    input logic                      in_clr,
    input logic [CW-1:0]             in_cut,
    input logic [LAGS-1:0][AW-1:0]   acc_re,
    input logic [LAGS-1:0][AW-1:0]   acc_im,
    input logic [LAGS-1:0][SUMW-1:0] sum_re,
    input logic [LAGS-1:0][SUMW-1:0] sum_im
);
    // R4: a trim of -TAPS or below leaves the last lag with no live tap
    p_low_trim_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && $signed(in_cut) <= -TAPS) |-> (sum_re[LAGS-1] == '0 && sum_im[LAGS-1] == '0));

    // R5: a positive trim up to LAGS-1 leaves lag 0 with no live tap
    p_high_trim_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && $signed(in_cut) > 0 && $signed(in_cut) <= LAGS-1)
        |-> (sum_re[0] == '0 && sum_im[0] == '0));

    for (genvar k = 0; k < LAGS; k++) begin : g_lag
        // R6: clear loads the new sum
        p_clear_load_r6: assert property (@(posedge clk) disable iff (rst)
            (fire && in_clr) |=>
            (acc_re[k] == AW'($signed($past(sum_re[k]))) &&
             acc_im[k] == AW'($signed($past(sum_im[k])))));

        // R1 / R8: accumulate with 16-bit wrap
        p_accumulate_r1: assert property (@(posedge clk) disable iff (rst)
            (fire && !in_clr) |=>
            (acc_re[k] == AW'($past(acc_re[k]) + AW'($signed($past(sum_re[k])))) &&
             acc_im[k] == AW'($past(acc_im[k]) + AW'($signed($past(sum_im[k]))))));

        // R7: no accepted operation, no change
        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !fire |=> ($stable(acc_re[k]) && $stable(acc_im[k])));

        // R9: reset clears every lag
        p_reset_zero_r9: assert property (@(posedge clk)
            rst |=> (acc_re[k] == '0 && acc_im[k] == '0));
    end
endmodule

bind pn_lag_correlator cor_lag_checker #(
    .LAGS(LAGS), .TAPS(TAPS), .AW(AW), .SUMW(SUMW), .CW(CW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .in_clr (in_clr),
    .in_cut (in_cut),
    .acc_re (acc_re_w),
    .acc_im (acc_im_w),
    .sum_re (sum_re_w),
    .sum_im (sum_im_w)
);

// File: tb/pn_lag_correlator_bench.sv
module pn_lag_correlator_bench;

    typedef struct {
        int          lag;
        logic [15:0] re;
        logic [15:0] im;
        string       req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic [45:0]  in_code = '0;
    logic [5:0]   in_cut = '0;
    logic         in_clr = 1'b0;
    logic [3:0]   rd_idx = '0;
    logic [15:0]  rd_re, rd_im;

    int errors = 0;
    int checks = 0;
    item_t sb[$];
    logic [15:0] m_re [16];
    logic [15:0] m_im [16];

    always #4 clk = ~clk;

    pn_lag_correlator u_pn_lag_correlator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_code(in_code), .in_cut(in_cut), .in_clr(in_clr),
        .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
    );

    // monitor: one expected item per cycle, compared mid-cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rd_re !== it.re || rd_im !== it.im || int'(rd_idx) != it.lag) begin
                errors++;
                $display("FAIL %s lag %0d: got re=%h im=%h, expected re=%h im=%h",
                         it.req, it.lag, rd_re, rd_im, it.re, it.im);
            end
        end
    end

    task automatic check_bit(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // model from the requirements: chip mask, sign rules, wrap
    function automatic bit live_of(int m, int c);
        if (c < 0) return m >= -c;
        if (c > 0) return m < c;
        return 1'b1;
    endfunction

    task automatic model_op(logic [127:0] d, logic [45:0] code, int c, bit clr);
        for (int k = 0; k < 16; k++) begin
            int sr = 0;
            int si = 0;
            for (int i = 0; i < 8; i++) begin
                int m = 15 - k + i;
                int a = int'($signed(d[16*i +: 8]));
                int b = int'($signed(d[16*i+8 +: 8]));
                int cr = code[2*m] ? -1 : 1;
                int ci = code[2*m+1] ? -1 : 1;
                if (live_of(m, c)) begin
                    sr += cr*a - ci*b;
                    si += ci*a + cr*b;
                end
            end
            m_re[k] = (clr ? 16'h0 : m_re[k]) + 16'(sr);
            m_im[k] = (clr ? 16'h0 : m_im[k]) + 16'(si);
        end
    endtask

    task automatic op(logic [127:0] d, logic [45:0] code, int c, bit clr);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d; in_code = code; in_cut = 6'(c); in_clr = clr;
        @(posedge clk);
        model_op(d, code, c, clr);
        #1 in_valid = 1'b0;
    endtask

    task automatic expect_lag(int k, logic [15:0] re, logic [15:0] im, string req);
        @(posedge clk); #1;
        rd_idx = 4'(k);
        sb.push_back('{k, re, im, req});
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < 16; k++) expect_lag(k, m_re[k], m_im[k], req);
        @(posedge clk);
    endtask

    function automatic logic [127:0] rnd_data();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [45:0] rnd_code();
        return {14'($urandom), $urandom};
    endfunction

    initial begin
        logic [127:0] p3_data;
        logic [45:0]  p3_code;
        for (int k = 0; k < 16; k++) begin m_re[k] = '0; m_im[k] = '0; end

        // R9: reset
        repeat (3) @(posedge clk);
        #1 check_bit("R9 ready in reset", in_ready, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1 check_bit("R9 ready after reset", in_ready, 1'b1);
        read_all("R9 reset totals");

        // R1, R3, R10: random beats, no trim
        op(rnd_data(), rnd_code(), 0, 1'b1);
        read_all("R10 read after clear");
        for (int n = 0; n < 4; n++) op(rnd_data(), rnd_code(), 0, 1'b0);
        read_all("R1 random accumulate");

        // R2: period-3 pattern, lags 0 and 3 in step, lag 1 out of step
        for (int i = 0; i < 8; i++) p3_data[16*i +: 16] = (i % 3 == 0) ? 16'h00FF : 16'h0001;
        for (int m = 0; m < 23; m++) p3_code[2*m +: 2] = (m % 3 == 0) ? 2'b11 : 2'b00;
        op(p3_data, p3_code, 0, 1'b1);
        op(p3_data, p3_code, 0, 1'b0);
        expect_lag(0, 16'h0010, 16'h0010, "R2 in step");
        expect_lag(1, 16'hFFF8, 16'hFFF8, "R2 out of step");
        expect_lag(3, 16'h0010, 16'h0010, "R2 in step lag3");
        read_all("R3 pattern all lags");

        // R4 / R5: tap counts with unit samples and +1+j chips
        op({8{16'h0001}}, '0, -7, 1'b1);
        expect_lag(15, 16'd1, 16'd1, "R4 trim -7 lag15");
        expect_lag(14, 16'd2, 16'd2, "R4 trim -7 lag14");
        expect_lag(13, 16'd3, 16'd3, "R4 trim -7 lag13");
        expect_lag(0,  16'd8, 16'd8, "R4 trim -7 lag0");
        op({8{16'h0001}}, '0, -15, 1'b1);
        expect_lag(1, 16'd7, 16'd7, "R4 trim -15 lag1");
        expect_lag(7, 16'd1, 16'd1, "R4 trim -15 lag7");
        expect_lag(8, 16'd0, 16'd0, "R4 trim -15 lag8");
        read_all("R4 trim -15 all");
        op({8{16'h0001}}, '0, 15, 1'b1);
        expect_lag(0, 16'd0, 16'd0, "R5 trim +15 lag0");
        expect_lag(1, 16'd1, 16'd1, "R5 trim +15 lag1");
        expect_lag(7, 16'd7, 16'd7, "R5 trim +15 lag7");
        expect_lag(8, 16'd8, 16'd8, "R5 trim +15 lag8");
        read_all("R5 trim +15 all");
        op(rnd_data(), rnd_code(), -23, 1'b1);
        read_all("R4 trim -23");
        op(rnd_data(), rnd_code(), 23, 1'b1);
        read_all("R5 trim +23");
        for (int n = 0; n < 6; n++) begin
            op(rnd_data(), rnd_code(), int'($signed(6'($urandom))), 1'b0);
            read_all("R4 R5 random trim");
        end

        // R8: wrap, -256 real per tap, 17 beats
        op({8{16'h8080}}, {23{2'b10}}, 0, 1'b1);
        for (int n = 0; n < 16; n++) op({8{16'h8080}}, {23{2'b10}}, 0, 1'b0);
        expect_lag(0, 16'h7800, 16'h0000, "R8 wrap");
        read_all("R8 wrap all");

        // R7: offered nothing while inputs toggle
        for (int n = 0; n < 6; n++) begin
            @(posedge clk); #1;
            in_data = rnd_data(); in_code = rnd_code(); in_cut = 6'($urandom); in_clr = 1'b1;
        end
        read_all("R7 hold");

        // R6: clear discards history
        op(rnd_data(), rnd_code(), 0, 1'b1);
        read_all("R6 clear");

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule